// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block is the processor-facing register file of a four-channel, byte-wide DMA controller. A host reaches it over a small I/O window with a 4-bit offset and 8-bit read and write data. Each channel keeps a base and a current 16-bit address and a base and a current 16-bit count. The block also holds a per-channel mask, a per-channel mode field, a controller-disable command bit and a terminal-count status nibble. Every 16-bit register is reached one byte at a time, and a single byte-pointer flip-flop shared by all address and count registers picks which byte.

The block drives the mask, the mode fields, the disable bit and every base and current value straight to a transfer engine. That engine reports the end of a transfer on a per-channel terminal-count input, and each pulse there sets the matching status bit. Data movement, page extension and arbitration between channels belong to other blocks.

Top module: `legacy_dma_regs`

## Requirements
- R1: Offsets 0 to 7 select channel `off[2:1]`. An even offset selects that channel's address register and an odd offset selects its count register.
- R2: One byte pointer is shared by all address and count accesses, reads and writes alike, and it starts at 0. Every access toggles it. An access made while it is 0 reaches the low byte and an access made while it is 1 reaches the high byte.
- R3: A byte write to an address or count register changes that byte of the base register, and in the same clock edge the whole new base value is copied into the current register.
- R4: A read of an address or count offset returns the selected byte of the current register.
- R5: A read of offset 8 returns the four terminal-count bits in `[3:0]`, with zeros in `[7:4]`, and then clears them. A high bit on `tc_in[i]` sets status bit i. A terminal count that arrives in the same cycle as a status read is kept for the next read.
- R6: A write to offset 10 changes the mask bit of channel `wdata[1:0]`. The bit is set when `wdata[2]` is 1 and cleared when it is 0. The other mask bits do not change.
- R7: A write to offset 11 loads `wdata[7:2]` into the mode field of channel `wdata[1:0]`. On `ch_mode` each channel i has 6 bits at `[6i+5:6i]`, laid out as `[1:0]` transfer type (2 = memory read, 1 = memory write), `[2]` auto-initialize, `[3]` address decrement and `[5:4]` the top two data bits.
- R8: A write to offset 12 clears the byte pointer. A write to offset 13 clears the byte pointer and sets all four mask bits. A write to offset 15 loads the mask from `wdata[3:0]`. None of these writes changes the address registers.
- R9: `ctrl_disable` follows bit 2 of the last write to offset 8. A read of offset 13 returns 0.
- R10: Reset clears the byte pointer, the mask, the modes, the status, the disable bit and every address and count. A read of offset 9, 10, 11, 12, 14 or 15 returns the last byte written to that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (when selected) |
| bus_off | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read cycle |
| tc_in | input | 4 | Per-channel terminal-count pulses from the engine |
| ctrl_disable | output | 1 | Controller disabled by command |
| ch_mask | output | 4 | Per-channel mask |
| ch_mode | output | 24 | Per-channel 6-bit mode fields |
| ch_base_addr | output | 64 | Base addresses, channel i at [16i+15:16i] |
| ch_cur_addr | output | 64 | Current addresses |
| ch_base_cnt | output | 64 | Base counts |
| ch_cur_cnt | output | 64 | Current counts |

## Verification
Two functions meet in one cycle when the engine reports a terminal count while the host reads the status register. The bench raises the status bit of one channel and then holds the status read on the same cycle as a terminal-count pulse on a different channel. The first read must return only the older bit. The next read must return only the bit that arrived during the clearing read, and a third read must return zero.

// File: rtl/dma_regs_pkg.sv
// Shared sizes and register offsets for the DMA register front end.
// Assumes a four-channel, byte-wide host window with 16-bit registers.
package dma_regs_pkg;
    localparam int unsigned DMA_NCH  = 4;
    localparam int unsigned DMA_DW   = 8;
    localparam int unsigned DMA_RW   = 2 * DMA_DW;
    localparam int unsigned DMA_MW   = DMA_DW - 2;

    localparam logic [3:0] OFF_STAT    = 4'd8;
    localparam logic [3:0] OFF_MASK1   = 4'd10;
    localparam logic [3:0] OFF_MODE    = 4'd11;
    localparam logic [3:0] OFF_PTRCLR  = 4'd12;
    localparam logic [3:0] OFF_MCLR    = 4'd13;
    localparam logic [3:0] OFF_MASKALL = 4'd15;
endpackage

// File: rtl/dma_chan_regs.sv
// One channel's base/current address and count registers.
// Assumes the word is exactly two data bytes; hi_sel picks the byte written.
module dma_chan_regs #(
    parameter int unsigned DW = 8,
    localparam int unsigned RW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          cnt_we,
    input  logic          hi_sel,
    input  logic [DW-1:0] wdata,
    output logic [RW-1:0] base_addr,
    output logic [RW-1:0] cur_addr,
    output logic [RW-1:0] base_cnt,
    output logic [RW-1:0] cur_cnt
);
    logic [RW-1:0] addr_nxt, cnt_nxt;

    // Merge the written byte into the old base word.
    always_comb begin
        addr_nxt = hi_sel ? {wdata, base_addr[DW-1:0]} : {base_addr[RW-1:DW], wdata};
        cnt_nxt  = hi_sel ? {wdata, base_cnt[DW-1:0]}  : {base_cnt[RW-1:DW], wdata};
    end

    // Address pair: base takes the byte, current takes the whole base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (addr_we) begin
            base_addr <= addr_nxt;
            cur_addr  <= addr_nxt;
        end
    end

    // Count pair: same reload rule as the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (cnt_we) begin
            base_cnt <= cnt_nxt;
            cur_cnt  <= cnt_nxt;
        end
    end

    // R3
    addr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |=> (cur_addr == base_addr));
    // R3
    cnt_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cur_cnt == base_cnt));
endmodule

// File: rtl/dma_ctrl_regs.sv
// Shared control state: byte pointer, mask, modes, status, disable bit
// and the readback shadow for offsets 8..15. Assumes NCH fits in wdata[1:0].
module dma_ctrl_regs
    import dma_regs_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 8,
    localparam int unsigned CHW = $clog2(NCH),
    localparam int unsigned MW  = DW - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic            rd_stb,
    input  logic [3:0]      off,
    input  logic [DW-1:0]   wdata,
    input  logic [NCH-1:0]  tc_in,
    output logic            ptr_q,
    output logic            dis_q,
    output logic [NCH-1:0]  mask_q,
    output logic [NCH*MW-1:0] mode_q,
    output logic [DW-1:0]   ctl_rdata
);
    logic [NCH-1:0] stat_q;
    logic [DW-1:0]  shadow_q [8];
    logic           rc_acc;
    logic           stat_rd;

    assign rc_acc  = (wr_stb | rd_stb) & ~off[3];
    assign stat_rd = rd_stb && (off == OFF_STAT);

    // Byte pointer: toggles per register access, cleared by two commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= 1'b0;
        else if (rc_acc)
            ptr_q <= ~ptr_q;
        else if (wr_stb && (off == OFF_PTRCLR || off == OFF_MCLR))
            ptr_q <= 1'b0;
    end

    // Mask bits: single-channel command, master clear, full load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_stb) begin
            if (off == OFF_MASK1) begin
                for (int i = 0; i < NCH; i++)
                    if (wdata[CHW-1:0] == CHW'(i))
                        mask_q[i] <= wdata[2];
            end else if (off == OFF_MCLR)
                mask_q <= '1;
            else if (off == OFF_MASKALL)
                mask_q <= wdata[NCH-1:0];
        end
    end

    // Mode fields: the channel named in the data takes the upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_stb && off == OFF_MODE) begin
            for (int i = 0; i < NCH; i++)
                if (wdata[CHW-1:0] == CHW'(i))
                    mode_q[i*MW +: MW] <= wdata[DW-1:2];
        end
    end

    // Command disable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dis_q <= 1'b0;
        else if (wr_stb && off == OFF_STAT)
            dis_q <= wdata[2];
    end

    // Status: read clears, terminal-count pulses set (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_rd ? '0 : stat_q) | tc_in;
    end

    // Readback shadow of the last byte written to offsets 8..15.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++)
                shadow_q[i] <= '0;
        end else if (wr_stb && off[3])
            shadow_q[off[2:0]] <= wdata;
    end

    // Read data for the upper half of the window.
    always_comb begin
        case (off)
            OFF_STAT: ctl_rdata = {{(DW-NCH){1'b0}}, stat_q};
            OFF_MCLR: ctl_rdata = '0;
            default:  ctl_rdata = shadow_q[off[2:0]];
        endcase
    end

    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rc_acc |=> (ptr_q != $past(ptr_q)));
    // R8
    mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && off == OFF_MCLR) |=> (mask_q == '1 && !ptr_q));
    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && off == OFF_MASK1 && wdata[2])
        |=> (mask_q == ($past(mask_q) | (NCH'(1) << $past(wdata[CHW-1:0])))));
    // R5
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && tc_in == '0) |=> (stat_q == '0));
    // R5
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_in) |=> ((stat_q & $past(tc_in)) == $past(tc_in)));
endmodule

// File: rtl/legacy_dma_regs.sv
// Top of the DMA register front end: decodes the host window, holds one
// register set per channel and muxes read data. Assumes four channels so
// that offset bits [2:1] name the channel.
module legacy_dma_regs
    import dma_regs_pkg::*;
#(
    parameter int unsigned NCH = DMA_NCH,
    parameter int unsigned DW  = DMA_DW,
    localparam int unsigned RW = 2 * DW,
    localparam int unsigned MW = DW - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_off,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    tc_in,
    output logic              ctrl_disable,
    output logic [NCH-1:0]    ch_mask,
    output logic [NCH*MW-1:0] ch_mode,
    output logic [NCH*RW-1:0] ch_base_addr,
    output logic [NCH*RW-1:0] ch_cur_addr,
    output logic [NCH*RW-1:0] ch_base_cnt,
    output logic [NCH*RW-1:0] ch_cur_cnt
);
    logic          wr_stb, rd_stb, ptr_q;
    logic [DW-1:0] ctl_rdata;
    logic [RW-1:0] cur_a [NCH];
    logic [RW-1:0] cur_c [NCH];
    logic [RW-1:0] rd_word;

    assign wr_stb = bus_sel & bus_wr;
    assign rd_stb = bus_sel & ~bus_wr;

    dma_ctrl_regs #(.NCH(NCH), .DW(DW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .off       (bus_off),
        .wdata     (bus_wdata),
        .tc_in     (tc_in),
        .ptr_q     (ptr_q),
        .dis_q     (ctrl_disable),
        .mask_q    (ch_mask),
        .mode_q    (ch_mode),
        .ctl_rdata (ctl_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = wr_stb && !bus_off[3] && (bus_off[2:1] == 2'(g));

        dma_chan_regs #(.DW(DW)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr_we   (hit && !bus_off[0]),
            .cnt_we    (hit && bus_off[0]),
            .hi_sel    (ptr_q),
            .wdata     (bus_wdata),
            .base_addr (ch_base_addr[g*RW +: RW]),
            .cur_addr  (ch_cur_addr[g*RW +: RW]),
            .base_cnt  (ch_base_cnt[g*RW +: RW]),
            .cur_cnt   (ch_cur_cnt[g*RW +: RW])
        );

        assign cur_a[g] = ch_cur_addr[g*RW +: RW];
        assign cur_c[g] = ch_cur_cnt[g*RW +: RW];
    end

    // Read mux: current word byte by pointer, else control readback.
    always_comb begin
        rd_word = bus_off[0] ? cur_c[bus_off[2:1]] : cur_a[bus_off[2:1]];
        if (!bus_off[3])
            bus_rdata = ptr_q ? rd_word[RW-1:DW] : rd_word[DW-1:0];
        else
            bus_rdata = ctl_rdata;
    end
endmodule

// File: tb/legacy_dma_regs_tb.sv
module legacy_dma_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_off = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  tc_in = '0;
    logic        ctrl_disable;
    logic [3:0]  ch_mask;
    logic [23:0] ch_mode;
    logic [63:0] ch_base_addr, ch_cur_addr, ch_base_cnt, ch_cur_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    legacy_dma_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tc_in(tc_in), .ctrl_disable(ctrl_disable), .ch_mask(ch_mask),
        .ch_mode(ch_mode), .ch_base_addr(ch_base_addr), .ch_cur_addr(ch_cur_addr),
        .ch_base_cnt(ch_base_cnt), .ch_cur_cnt(ch_cur_cnt)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, input logic [7:0] exp,
                      input string tag, input logic [3:0] tc = 4'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_off = off; tc_in = tc;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0; tc_in = '0;
    endtask

    task automatic tc_pulse(input logic [3:0] v);
        @(negedge clk); tc_in = v;
        @(negedge clk); tc_in = '0;
    endtask

    // Monitor: compares each read byte with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (bus_sel && !bus_wr) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL scoreboard: unexpected read got %0h expected none", bus_rdata);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({56'h0, bus_rdata}, {56'h0, e}, t);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(ch_mask, 0, "R10 mask after reset");
        check(ch_mode, 0, "R10 mode after reset");
        check(ctrl_disable, 0, "R10 disable after reset");
        check(ch_cur_addr, 0, "R10 addresses after reset");
        rd(4'd8, 8'h00, "R10 status after reset");

        // R1 R3 address of channel 1, low then high
        wr(4'd2, 8'h34); wr(4'd2, 8'h12);
        check(ch_base_addr[31:16], 16'h1234, "R1 R3 base addr ch1");
        check(ch_cur_addr[31:16], 16'h1234, "R3 cur addr ch1");
        rd(4'd2, 8'h34, "R2 R4 addr low byte");
        rd(4'd2, 8'h12, "R2 R4 addr high byte");

        // R8 pointer clear repeats the low byte
        wr(4'd7, 8'hCD); wr(4'd7, 8'hAB);
        check(ch_base_cnt[63:48], 16'hABCD, "R1 base cnt ch3");
        check(ch_cur_cnt[63:48], 16'hABCD, "R3 cur cnt ch3");
        rd(4'd7, 8'hCD, "R4 cnt low byte");
        wr(4'd12, 8'h00);
        rd(4'd7, 8'hCD, "R8 pointer clear");
        wr(4'd12, 8'h00);

        // R2 pointer shared between address and count
        wr(4'd5, 8'h78); wr(4'd5, 8'h56);
        wr(4'd4, 8'h9A);
        check(ch_cur_addr[47:32], 16'h009A, "R3 partial addr ch2");
        rd(4'd5, 8'h56, "R2 shared pointer gives high byte");

        // R5 status read and clear
        tc_pulse(4'b0101);
        rd(4'd8, 8'h05, "R5 status set");
        rd(4'd8, 8'h00, "R5 status cleared by read");
        // R5 terminal count in the same cycle as the clearing read
        tc_pulse(4'b1000);
        rd(4'd8, 8'h08, "R5 read during new tc", 4'b0010);
        rd(4'd8, 8'h02, "R5 same-cycle tc kept");
        rd(4'd8, 8'h00, "R5 status empty");

        // R6 single mask command
        wr(4'd10, 8'h06);
        check(ch_mask, 4'b0100, "R6 mask ch2");
        wr(4'd10, 8'h07);
        check(ch_mask, 4'b1100, "R6 mask ch3");
        wr(4'd10, 8'h02);
        check(ch_mask, 4'b1000, "R6 unmask ch2");

        // R7 mode fields
        wr(4'd11, 8'hB9);
        check(ch_mode, 24'h000B80, "R7 mode ch1");
        rd(4'd11, 8'hB9, "R10 mode readback");
        wr(4'd11, 8'h46);
        check(ch_mode, 24'h011B80, "R7 mode ch2");

        // R8 full mask load
        wr(4'd15, 8'hFA);
        check(ch_mask, 4'hA, "R8 mask load");
        rd(4'd15, 8'hFA, "R10 offset 15 readback");

        // R9 command disable
        wr(4'd8, 8'h04);
        check(ctrl_disable, 1, "R9 disable set");
        rd(4'd8, 8'h00, "R5 status not command");
        wr(4'd8, 8'h00);
        check(ctrl_disable, 0, "R9 disable cleared");

        // R8 master clear
        wr(4'd0, 8'h55);
        wr(4'd13, 8'h3C);
        check(ch_mask, 4'hF, "R8 master clear masks");
        check(ch_cur_addr[15:0], 16'h0055, "R8 master clear keeps address");
        rd(4'd13, 8'h00, "R9 offset 13 reads zero");
        rd(4'd2, 8'h34, "R8 master clear resets pointer");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule